// File: doc/BRIEF.md
# Interrupt Request Arbiter

This block sits beside the instruction sequencer. In each cycle where the sequencer reports that an instruction has just completed, the block looks at every source that can break program flow. These sources are the internal exceptions raised by the finished instruction, a latched edge from the non-maskable pin, the maskable request line and the trap flag. The block then decides whether an interrupt must be entered.

When an interrupt is due, the block gives a one-cycle take strobe in the cycle after the boundary, together with the 8-bit type number to service. A separate flag marks the case where the type is not known inside the processor. In that case the sequencer must fetch the type from an external controller, and the type output then reads zero.

The entry stack sequence and the acknowledge bus cycles belong to the sequencer.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after reset, take_o is 0, type_o is 0 and ext_o is 0.
- R2: take_o rises only in the cycle after a cycle with boundary_i high that has at least one active source. It lasts one cycle. When take_o is low, type_o and ext_o are 0.
- R3: A divide error (exc_div_i) at a boundary yields type 0 and outranks every other source.
- R4: A software interrupt (exc_swi_i) yields the 8-bit operand on swi_type_i as the type. An operand of 3 gives type 3.
- R5: An overflow-trap instruction (exc_into_i) yields type 4 only when ovf_flag_i is 1. With ovf_flag_i at 0 it has no effect, and lower sources are arbitrated as if it were absent.
- R6: A low-to-high transition of nmi_pin_i is latched as a pending request of type 2, whatever ie_flag_i holds. Once it is serviced, a pin that stays high raises nothing further.
- R7: A pending non-maskable request stays pending across boundaries won by a higher source. It is cleared only when it is itself taken.
- R8: intr_req_i is accepted only while ie_flag_i is 1. It gives ext_o = 1 with type_o = 0.
- R9: trap_flag_i at a boundary yields type 1 when no other source is active.
- R10: The priority, highest first, is divide error, software interrupt, overflow trap, non-maskable, maskable, single-step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary_i | input | 1 | Current instruction has completed this cycle |
| exc_div_i | input | 1 | Divide error raised by the completed instruction |
| exc_swi_i | input | 1 | Software interrupt instruction completed |
| swi_type_i | input | 8 | Operand of the software interrupt |
| exc_into_i | input | 1 | Overflow-trap instruction completed |
| ovf_flag_i | input | 1 | Overflow flag |
| nmi_pin_i | input | 1 | Non-maskable request pin, edge sensitive |
| intr_req_i | input | 1 | Maskable request line, active high |
| ie_flag_i | input | 1 | Interrupt-enable flag |
| trap_flag_i | input | 1 | Single-step trap flag |
| take_o | output | 1 | Enter an interrupt now |
| type_o | output | 8 | Type number to service |
| ext_o | output | 1 | Type must be read from the external controller |

## Verification
The assertions assume that the exception inputs and the flags hold valid values in every cycle where boundary_i is high. They also assume that nmi_pin_i is low or steady through reset, so that leaving reset creates no false edge.

The bench meets these assumptions by changing every input only on falling clock edges. It raises the exception inputs only together with boundary_i and clears them in the next cycle. It holds the non-maskable pin low during reset.

It sweeps all 256 combinations of the seven request and flag inputs and a pending non-maskable edge. After each combination it issues a bare boundary, which shows whether the latched edge was kept or consumed.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Source indices, ordered from highest to lowest priority
    localparam int SRC_DIV  = 0;
    localparam int SRC_SWI  = 1;
    localparam int SRC_INTO = 2;
    localparam int SRC_NMI  = 3;
    localparam int SRC_INTR = 4;
    localparam int SRC_STEP = 5;
    localparam int NSRC     = 6;

    // Dedicated type numbers
    localparam int TYP_DIV  = 0;
    localparam int TYP_STEP = 1;
    localparam int TYP_NMI  = 2;
    localparam int TYP_OVF  = 4;

    function automatic int fixed_type(int src);
        case (src)
            SRC_DIV:  return TYP_DIV;
            SRC_INTO: return TYP_OVF;
            SRC_NMI:  return TYP_NMI;
            SRC_STEP: return TYP_STEP;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q, prev_d;
    logic pend_q, pend_d;

    always_comb begin
        prev_d = pin_i;
        // a fresh edge wins over a clear in the same cycle
        pend_d = (pend_q & ~clr_i) | (pin_i & ~prev_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !clr_i |=> pend_q); // R7

endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic [NSRC-1:0]   req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    output logic              any_o,
    output logic [NSRC-1:0]   grant_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              ext_o
);
    logic found;

    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
        any_o = found;
    end

    always_comb begin
        type_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant_o[i]) type_o = TYPE_W'(fixed_type(i));
        end
        if (grant_o[SRC_SWI]) type_o = swi_type_i;
        ext_o = grant_o[SRC_INTR];
    end

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R10
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              exc_div_i,
    input  logic              exc_swi_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic              exc_into_i,
    input  logic              ovf_flag_i,
    input  logic              nmi_pin_i,
    input  logic              intr_req_i,
    input  logic              ie_flag_i,
    input  logic              trap_flag_i,
    output logic              take_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              ext_o
);
    typedef struct packed {
        logic              take;
        logic              ext;
        logic [TYPE_W-1:0] vtype;
    } out_s;

    out_s st_d, st_q;

    logic              nmi_pend;
    logic              nmi_clr;
    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   grant;
    logic              any;
    logic [TYPE_W-1:0] win_type;
    logic              win_ext;

    irq_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmi_pin_i),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    always_comb begin
        req           = '0;
        req[SRC_DIV]  = exc_div_i;
        req[SRC_SWI]  = exc_swi_i;
        req[SRC_INTO] = exc_into_i & ovf_flag_i;
        req[SRC_NMI]  = nmi_pend;
        req[SRC_INTR] = intr_req_i & ie_flag_i;
        req[SRC_STEP] = trap_flag_i;
    end

    irq_resolve #(.TYPE_W(TYPE_W)) u_res (
        .req_i      (req),
        .swi_type_i (swi_type_i),
        .any_o      (any),
        .grant_o    (grant),
        .type_o     (win_type),
        .ext_o      (win_ext)
    );

    assign nmi_clr = boundary_i & grant[SRC_NMI];

    always_comb begin
        st_d       = '0;
        st_d.take  = boundary_i & any;
        if (st_d.take) begin
            st_d.ext   = win_ext;
            st_d.vtype = win_type;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o = st_q.take;
    assign type_o = st_q.vtype;
    assign ext_o  = st_q.ext;

    AST_TAKE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i)); // R2

    AST_DIV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_i && exc_div_i |=> take_o && type_o == '0 && !ext_o); // R3

    AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_o |-> $past(intr_req_i && ie_flag_i)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> type_o == '0 && !ext_o); // R2

endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary = 0, div = 0, swi = 0, into = 0, ovf = 0;
    logic nmi = 0, intr = 0, ie = 0, trap = 0;
    logic [7:0] swi_type = '0;
    logic take, ext;
    logic [7:0] vtype;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary),
        .exc_div_i(div), .exc_swi_i(swi), .swi_type_i(swi_type),
        .exc_into_i(into), .ovf_flag_i(ovf), .nmi_pin_i(nmi),
        .intr_req_i(intr), .ie_flag_i(ie), .trap_flag_i(trap),
        .take_o(take), .type_o(vtype), .ext_o(ext)
    );

    task automatic check(string tag, logic et, logic [7:0] ety, logic ee);
        checks++;
        if (take !== et || vtype !== ety || ext !== ee) begin
            fails++;
            $display("FAIL %s: take/type/ext = %0b/%0d/%0b expected %0b/%0d/%0b",
                     tag, take, vtype, ext, et, ety, ee);
        end
    endtask

    task automatic clear_inputs();
        boundary = 0; div = 0; swi = 0; into = 0; ovf = 0;
        intr = 0; ie = 0; trap = 0;
    endtask

    // one boundary with current inputs, then check result and quiet cycle
    task automatic fire(string tag, logic et, logic [7:0] ety, logic ee);
        boundary = 1;
        @(negedge clk);
        clear_inputs();
        check(tag, et, ety, ee);
        @(negedge clk);
        check("R2", 1'b0, 8'd0, 1'b0);
    endtask

    task automatic nmi_edge();
        nmi = 1;
        @(negedge clk);
        nmi = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 8'd0, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check("R1", 1'b0, 8'd0, 1'b0);

        // INT 3 gives type 3
        swi = 1; swi_type = 8'd3;
        fire("R4", 1'b1, 8'd3, 1'b0);

        // held NMI level: one service only
        nmi = 1;
        @(negedge clk);
        @(negedge clk);
        fire("R6", 1'b1, 8'd2, 1'b0);
        fire("R6", 1'b0, 8'd0, 1'b0);
        nmi = 0;
        @(negedge clk);

        // full sweep of request and flag combinations
        for (int c = 0; c < 256; c++) begin
            logic       et, ee;
            logic [7:0] ety;
            string      tag;
            int         nsrc;
            logic       nmi_won;
            if (c[7]) nmi_edge();
            div = c[0]; swi = c[1]; into = c[2]; ovf = c[3];
            intr = c[4]; ie = c[5]; trap = c[6];
            swi_type = 8'((c * 37 + 11) % 256);
            nsrc = int'(c[0]) + int'(c[1]) + int'(c[2] & c[3]) + int'(c[7])
                 + int'(c[4] & c[5]) + int'(c[6]);
            et = 1; ee = 0; ety = 0; nmi_won = 0;
            if (c[0])              begin ety = 8'd0;     tag = "R3"; end
            else if (c[1])         begin ety = swi_type; tag = "R4"; end
            else if (c[2] && c[3]) begin ety = 8'd4;     tag = "R5"; end
            else if (c[7])         begin ety = 8'd2;     tag = "R6"; nmi_won = 1; end
            else if (c[4] && c[5]) begin ee = 1;         tag = "R8"; end
            else if (c[6])         begin ety = 8'd1;     tag = "R9"; end
            else                   begin et = 0;         tag = "R2"; end
            if (nsrc > 1) tag = {tag, " R10"};
            if (c[2] && !c[3] && nsrc == 0) tag = "R5";
            if (c[4] && !c[5] && nsrc == 0) tag = "R8";
            fire(tag, et, ety, ee);
            // bare boundary: pending NMI must be served only if not yet taken
            if (c[7] && !nmi_won) fire("R7", 1'b1, 8'd2, 1'b0);
            else                  fire("R7", 1'b0, 8'd0, 1'b0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule